// File: doc/BRIEF.md
# Four-Phase Serializer with Two-Tap Pre-Emphasis

The block turns a parallel word, offered once per word period, into a serial stream at one bit per fast clock cycle. A free-running phase counter on the fast clock stands in for a set of evenly spaced clock phases. Each word period spans `LANES` fast cycles, and each phase is active for two consecutive cycles, so adjacent phases overlap in exactly one cycle. The incoming word is caught once per period in a core register. Each bit is then moved into its own per-phase holding register. The bit of slot k reaches the line only in the cycle where phase k and phase k+1 are both active.

A two-tap transmit filter runs on every serial bit. The main tap adds its weight with the polarity of the current bit, and the post tap adds its weight with the opposite polarity of the bit before it. The sum is a signed drive code that feeds a current-steering driver outside the block. Both tap weights come in on ports, so one build can serve channels with different losses. When no valid word is offered, the serializer sends zeros and the filter keeps running on them.

Top module: `phase_ser_pe`

## Requirements
- R1: While rst_ni is low, ser_o is 0 and drive_o is 0.
- R2: Cycles are counted from the first fast cycle after reset release, which is cycle 0. The word on word_i is sampled at the rising edge that ends cycle 4n+3, for frame n. Its bits appear on ser_o in cycles 4n+6 to 4n+9. Before cycle 6, ser_o is 0.
- R3: Within a word, bit 0 is sent first and bit 3 last. Each bit is held on ser_o for exactly one fast cycle.
- R4: Values on word_i and valid_i in any cycle other than 4n+3 have no effect on ser_o or drive_o.
- R5: drive_o changes together with ser_o. Its value is +main_wt_i when the current bit is 1 and -main_wt_i when it is 0. To that is added -post_wt_i when the previous serial bit is 1, or +post_wt_i when it is 0. The weights are unsigned and are sampled at the same edge that loads the bit.
- R6: The drive code is two's complement. A sum outside [-2^(DW-1), 2^(DW-1)-1] is clamped to the nearer limit, which is -16 or +15 for the default DW=5.
- R7: A word sampled with valid_i low is sent as all zeros. The filter is still applied to that word, so a 0 that follows a 1 gives -main-post and a 0 that follows a 0 gives -main+post.
- R8: The previous-bit term runs across word boundaries: bit 0 of a word uses bit 3 of the word before it. After reset, the previous bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one cycle per serial bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | LANES | Parallel word, bit 0 sent first |
| valid_i | input | 1 | Word-valid strobe, sampled together with word_i |
| main_wt_i | input | WW | Main-tap weight, unsigned |
| post_wt_i | input | WW | Post-tap weight, unsigned |
| ser_o | output | 1 | Serial bit |
| drive_o | output | DW | Signed drive code for the current bit |

## Verification
The assertions take two things about the inputs for granted. Reset is released with the phase counter at zero, so the frame boundaries the bench counts match the design's capture edge. The tap weights are unsigned magnitudes, so a rising serial edge always carries a non-negative code and a falling edge a non-positive one. The stimulus releases reset on a falling clock edge and counts cycles from there. It changes the weights only between edges. Between capture edges it fills word_i and valid_i with random values, so that only the capture cycle decides what is sent.

// File: rtl/pser_pkg.sv
package pser_pkg;
  localparam int unsigned LANES_DEF = 4;
  localparam int unsigned WW_DEF    = 4;
  localparam int unsigned DW_DEF    = 5;

  function automatic int clamp(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/pser_phase_gen.sv
module pser_phase_gen #(
  parameter  int unsigned NPH = 4,
  localparam int unsigned PW  = $clog2(NPH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [PW-1:0]  ph_o,
  output logic [NPH-1:0] ph_on_o,
  output logic           cap_o
);
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ph_q <= '0;
    else if (ph_q == PW'(NPH - 1)) ph_q <= '0;
    else                           ph_q <= ph_q + PW'(1);
  end

  // phase k is high for two cycles: counts k and k+1
  for (genvar k = 0; k < NPH; k++) begin : g_on
    assign ph_on_o[k] = (ph_q == PW'(k)) || (ph_q == PW'((k + 1) % NPH));
  end

  assign ph_o  = ph_q;
  assign cap_o = (ph_q == PW'(NPH - 1));
endmodule

// File: rtl/pser_retime.sv
module pser_retime #(
  parameter  int unsigned NPH = 4,
  localparam int unsigned PW  = $clog2(NPH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [PW-1:0]  ph_i,
  input  logic           cap_i,
  input  logic [NPH-1:0] word_i,
  input  logic           valid_i,
  output logic [NPH-1:0] slot_o
);
  logic [NPH-1:0] core_q;
  logic [NPH-1:0] slot_q;

  // single word-rate domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    core_q <= '0;
    else if (cap_i) core_q <= valid_i ? word_i : '0;
  end

  // per-phase domains: slot k is refreshed on its own phase
  for (genvar k = 0; k < NPH; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                slot_q[k] <= 1'b0;
      else if (ph_i == PW'(k))    slot_q[k] <= core_q[k];
    end

    a_r2_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_i != PW'(k)) |=> $stable(slot_q[k]));
  end

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !valid_i) |=> (core_q == '0));

  assign slot_o = slot_q;
endmodule

// File: rtl/pser_slot_mux.sv
module pser_slot_mux #(
  parameter int unsigned NPH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] ph_on_i,
  input  logic [NPH-1:0] slot_i,
  output logic           bit_o
);
  logic [NPH-1:0] sel;

  for (genvar k = 0; k < NPH; k++) begin : g_sel
    assign sel[k] = ph_on_i[k] & ph_on_i[(k + 1) % NPH];
  end

  assign bit_o = |(sel & slot_i);

  a_r3_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel) == 1);
endmodule

// File: rtl/pser_fir2.sv
module pser_fir2 #(
  parameter int unsigned WW = 4,
  parameter int unsigned DW = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_i,
  input  logic [WW-1:0]        main_wt_i,
  input  logic [WW-1:0]        post_wt_i,
  output logic                 ser_o,
  output logic signed [DW-1:0] drive_o
);
  localparam int HI = (2 ** (DW - 1)) - 1;
  localparam int LO = -(2 ** (DW - 1));

  logic                 ser_q;   // also the previous-bit tap
  logic signed [DW-1:0] drive_q;
  logic signed [DW-1:0] drive_d;
  int                   mw, pw, raw;

  always_comb begin
    mw      = int'(main_wt_i);
    pw      = int'(post_wt_i);
    raw     = (bit_i ? mw : -mw) + (ser_q ? -pw : pw);
    drive_d = DW'(pser_pkg::clamp(raw, LO, HI));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q   <= 1'b0;
      drive_q <= '0;
    end else begin
      ser_q   <= bit_i;
      drive_q <= drive_d;
    end
  end

  assign ser_o   = ser_q;
  assign drive_o = drive_q;
endmodule

// File: rtl/phase_ser_pe.sv
module phase_ser_pe #(
  parameter int unsigned LANES = pser_pkg::LANES_DEF,
  parameter int unsigned WW    = pser_pkg::WW_DEF,
  parameter int unsigned DW    = pser_pkg::DW_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LANES-1:0]     word_i,
  input  logic                 valid_i,
  input  logic [WW-1:0]        main_wt_i,
  input  logic [WW-1:0]        post_wt_i,
  output logic                 ser_o,
  output logic signed [DW-1:0] drive_o
);
  localparam int unsigned PW = $clog2(LANES);

  logic [PW-1:0]    ph;
  logic [LANES-1:0] ph_on;
  logic             cap;
  logic [LANES-1:0] slot;
  logic             mux_bit;

  pser_phase_gen #(.NPH(LANES)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_o(ph), .ph_on_o(ph_on), .cap_o(cap)
  );

  pser_retime #(.NPH(LANES)) u_retime (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_i(ph), .cap_i(cap),
    .word_i(word_i), .valid_i(valid_i), .slot_o(slot)
  );

  pser_slot_mux #(.NPH(LANES)) u_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_on_i(ph_on), .slot_i(slot), .bit_o(mux_bit)
  );

  pser_fir2 #(.WW(WW), .DW(DW)) u_fir (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(mux_bit),
    .main_wt_i(main_wt_i), .post_wt_i(post_wt_i),
    .ser_o(ser_o), .drive_o(drive_o)
  );

  // R5: unsigned weights give a non-negative code on a rising bit, non-positive on a falling one
  a_r5_rise_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_o) |-> !drive_o[DW-1]);
  a_r5_fall_nonpos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_o) |-> (drive_o[DW-1] || (drive_o == '0)));
endmodule

// File: tb/phase_ser_pe_tb.sv
`timescale 1ns/1ps
module phase_ser_pe_tb;
  localparam int LANES = 4;
  localparam int WW    = 4;
  localparam int DW    = 5;
  localparam int NCYC  = 1200;
  localparam int HI    = 15;
  localparam int LO    = -16;

  // {valid, word[3:0], main[3:0], post[3:0]}, one entry per frame
  localparam logic [12:0] TBL [16] = '{
    {1'b1, 4'b0001, 4'd4,  4'd1},
    {1'b1, 4'b1000, 4'd4,  4'd1},
    {1'b1, 4'b1010, 4'd6,  4'd2},
    {1'b1, 4'b0101, 4'd6,  4'd2},
    {1'b1, 4'b1111, 4'd3,  4'd0},
    {1'b1, 4'b0000, 4'd3,  4'd3},
    {1'b0, 4'b1111, 4'd5,  4'd2},
    {1'b1, 4'b1111, 4'd5,  4'd2},
    {1'b0, 4'b0110, 4'd5,  4'd2},
    {1'b1, 4'b0101, 4'd15, 4'd15},
    {1'b1, 4'b1010, 4'd15, 4'd15},
    {1'b1, 4'b0011, 4'd12, 4'd9},
    {1'b1, 4'b1100, 4'd0,  4'd7},
    {1'b1, 4'b1001, 4'd0,  4'd0},
    {1'b0, 4'b0000, 4'd15, 4'd15},
    {1'b1, 4'b0111, 4'd9,  4'd8}
  };

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [LANES-1:0]     word_i = '0;
  logic                 valid_i = 1'b0;
  logic [WW-1:0]        main_wt_i = '0;
  logic [WW-1:0]        post_wt_i = '0;
  logic                 ser_o;
  logic signed [DW-1:0] drive_o;

  int checks = 0;
  int fails  = 0;
  logic [LANES-1:0] rec_word [NCYC];
  logic             rec_val  [NCYC];
  int               rec_m    [NCYC];
  int               rec_p    [NCYC];

  always #4 clk = ~clk;

  phase_ser_pe #(.LANES(LANES), .WW(WW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .valid_i(valid_i),
    .main_wt_i(main_wt_i), .post_wt_i(post_wt_i), .ser_o(ser_o), .drive_o(drive_o)
  );

  function automatic logic exp_bit(input int m);
    int n, k, c;
    if (m < 6) return 1'b0;
    n = (m - 6) / 4;
    k = (m - 6) % 4;
    c = 4 * n + 3;
    return rec_val[c] ? rec_word[c][k] : 1'b0;
  endfunction

  function automatic logic exp_idle(input int m);
    if (m < 6) return 1'b1;
    return !rec_val[4 * ((m - 6) / 4) + 3];
  endfunction

  task automatic chk(input string tag, input int got, input int exp, input int cyc);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s cycle %0d got %0d expected %0d", tag, cyc, got, exp);
    end
  endtask

  task automatic check_out(input int m);
    logic cur, prv;
    int raw, expd;
    string tag;
    cur  = exp_bit(m);
    prv  = (m >= 2) ? exp_bit(m - 1) : 1'b0;
    raw  = (cur ? rec_m[m-1] : -rec_m[m-1]) + (prv ? -rec_p[m-1] : rec_p[m-1]);
    expd = (raw > HI) ? HI : (raw < LO) ? LO : raw;
    if (m < 6)                       tag = "R2 ser";
    else if (exp_idle(m))            tag = "R7 ser";
    else                             tag = "R3 R4 ser";
    chk(tag, int'(ser_o), int'(cur), m);
    if (raw != expd)                 tag = "R6 drive";
    else if (m >= 6 && (m - 6) % 4 == 0) tag = "R8 drive";
    else if (exp_idle(m))            tag = "R7 drive";
    else                             tag = "R5 drive";
    chk(tag, int'(drive_o), expd, m);
  endtask

  task automatic drive_cycle(input int c);
    int f, p;
    logic [12:0] e;
    f = c / 4;
    p = c % 4;
    if (p == 0) begin
      if (f < 16) begin
        e = TBL[f];
        main_wt_i = e[7:4];
        post_wt_i = e[3:0];
      end else begin
        main_wt_i = WW'($urandom);
        post_wt_i = WW'($urandom);
      end
    end
    if (p == 3) begin
      if (f < 16) begin
        e = TBL[f];
        valid_i = e[12];
        word_i  = e[11:8];
      end else begin
        valid_i = ($urandom % 4) != 0;
        word_i  = LANES'($urandom);
      end
    end else begin
      // R4: junk outside the capture cycle
      valid_i = 1'($urandom);
      word_i  = LANES'($urandom);
    end
    rec_word[c] = word_i;
    rec_val[c]  = valid_i;
    rec_m[c]    = int'(main_wt_i);
    rec_p[c]    = int'(post_wt_i);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ser reset", int'(ser_o), 0, 0);
    chk("R1 drive reset", int'(drive_o), 0, 0);
    rst_ni = 1'b1;
    for (int c = 0; c < NCYC - 1; c++) begin
      drive_cycle(c);
      @(negedge clk);
      check_out(c + 1);
    end
    // reset again mid-stream
    word_i = 4'b1111; valid_i = 1'b1; main_wt_i = 4'd9; post_wt_i = 4'd3;
    rst_ni = 1'b0;
    #1;
    chk("R1 ser async reset", int'(ser_o), 0, 0);
    chk("R1 drive async reset", int'(drive_o), 0, 0);
    repeat (4) @(negedge clk);
    chk("R1 ser held reset", int'(ser_o), 0, 0);
    chk("R1 drive held reset", int'(drive_o), 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule